// File: doc/BRIEF.md
# Latched 4-to-16 Line Decoder

This block turns a four-bit address into a sixteen-line select bus on which exactly one line is active. The address does not reach the decoder directly. It first passes through a level-sensitive holding stage that a strobe controls. While the strobe is high, the stage follows the address. When the strobe falls, the stage keeps the value that was present at that moment.

An inhibit input drives every select line to its inactive level. It does not disturb the held address, and the holding stage keeps working while inhibit is asserted.

A compile-time parameter selects the output polarity. In the active-high build the chosen line is high and all others are low. The active-low build gives the bitwise complement. The block has no clock and no reset.

Top module: `latched_line_decoder`

## Requirements
- R1: While `strobe_i` is high, the held address equals `addr_i`, and the select bus follows `addr_i` with no clock.
- R2: After `strobe_i` falls, the address present at the falling transition is held and keeps driving the decode while `strobe_i` stays low, whatever `addr_i` does.
- R3: With `inhibit_i` low, exactly one bit of the select bus is at its active level. That bit is `sel_o[n]`, where n is the held address.
- R4: Address bit weights are `addr_i[0]` = 1, `addr_i[1]` = 2, `addr_i[2]` = 4 and `addr_i[3]` = 8. Only bit 0 set selects `sel_o[1]`; only bit 3 set selects `sel_o[8]`.
- R5: With `inhibit_i` high, all sixteen select bits are inactive for any address: all 0 when `ACTIVE_LOW` = 0 and all 1 when `ACTIVE_LOW` = 1.
- R6: Strobe activity while `inhibit_i` is high still updates the held address. That address appears on the select bus once `inhibit_i` returns low.
- R7: For every input sequence, the select bus of the `ACTIVE_LOW` = 1 build is the exact bitwise complement of the `ACTIVE_LOW` = 0 build.
- R8: `ACTIVE_LOW` defaults to 0, which is the active-high build.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| strobe_i | input | 1 | High: holding stage transparent; low: holds address |
| inhibit_i | input | 1 | High forces all select lines inactive |
| addr_i | input | ADDR_W (4) | Address, bit 0 least significant |
| sel_o | output | 2**ADDR_W (16) | One-hot select bus, polarity per ACTIVE_LOW |

## Verification
A holding stage that stores a wrong value shows up at the ports at once. The error is visible as soon as inhibit is low: the wrong line is selected, or no line is. Its cause, however, may go back to a strobe fall many steps earlier. For this reason the bench tracks the expected held address across long strobe-low stretches and inhibit windows, not only in transparent mode. Polarity or gating faults appear as more than one active line, or as an active line during inhibit, in the same step as the input change.

// File: rtl/lld_pkg.sv
package lld_pkg;

  typedef enum logic {
    POL_HIGH = 1'b0,
    POL_LOW  = 1'b1
  } pol_e;

  // Physical output level of one line, given whether it is selected.
  function automatic logic line_level(input logic selected, input logic gate_open,
                                      input pol_e pol);
    logic active;
    active = selected & gate_open;
    return (pol == POL_LOW) ? ~active : active;
  endfunction

  // Equality test of a line index against an address.
  function automatic logic index_hit(input int unsigned line, input int unsigned addr);
    return line == addr;
  endfunction

endpackage

// File: rtl/lld_addr_hold.sv
module lld_addr_hold #(
  parameter int ADDR_W = 4
) (
  input  logic              open_i,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);
  // Level-sensitive holding stage, transparent while open_i is high.
  always_latch begin
    if (open_i) q_o = d_i;
  end
endmodule

// File: rtl/lld_onehot.sv
module lld_onehot #(
  parameter int ADDR_W = 4,
  localparam int LINES = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] idx_i,
  output logic [LINES-1:0]  hot_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign hot_o[g] = lld_pkg::index_hit(g, int'(idx_i));
  end
endmodule

// File: rtl/lld_out_stage.sv
module lld_out_stage #(
  parameter int   LINES = 16,
  parameter logic ACTIVE_LOW = 1'b0
) (
  input  logic [LINES-1:0] hot_i,
  input  logic             gate_open_i,
  output logic [LINES-1:0] sel_o
);
  localparam lld_pkg::pol_e POL = ACTIVE_LOW ? lld_pkg::POL_LOW : lld_pkg::POL_HIGH;

  for (genvar g = 0; g < LINES; g++) begin : g_drv
    assign sel_o[g] = lld_pkg::line_level(hot_i[g], gate_open_i, POL);
  end
endmodule

// File: rtl/latched_line_decoder.sv
module latched_line_decoder #(
  parameter int   ADDR_W     = 4,
  parameter logic ACTIVE_LOW = 1'b0
) (
  input  logic                     strobe_i,
  input  logic                     inhibit_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [(1<<ADDR_W)-1:0]   sel_o
);
  localparam int LINES = 1 << ADDR_W;

  // Named internal events, used by the bound checker.
  logic [ADDR_W-1:0] held_addr;
  logic [LINES-1:0]  hot_vec;
  logic              gate_open;

  assign gate_open = ~inhibit_i;

  lld_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .open_i (strobe_i),
    .d_i    (addr_i),
    .q_o    (held_addr)
  );

  lld_onehot #(.ADDR_W(ADDR_W)) u_dec (
    .idx_i (held_addr),
    .hot_o (hot_vec)
  );

  lld_out_stage #(.LINES(LINES), .ACTIVE_LOW(ACTIVE_LOW)) u_out (
    .hot_i       (hot_vec),
    .gate_open_i (gate_open),
    .sel_o       (sel_o)
  );
endmodule

// File: rtl/lld_checker.sv
module lld_checker #(
  parameter int   ADDR_W     = 4,
  parameter logic ACTIVE_LOW = 1'b0
) (
  input logic                   strobe_i,
  input logic                   inhibit_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [ADDR_W-1:0]      held_addr,
  input logic [(1<<ADDR_W)-1:0] sel_o
);
  logic [(1<<ADDR_W)-1:0] act;
  logic primed = 1'b0;

  // The holding stage has no reset; decode checks start after the first strobe.
  always_ff @(posedge strobe_i) primed <= 1'b1;

  assign act = ACTIVE_LOW ? ~sel_o : sel_o;

  always_comb begin
    if (strobe_i)
      p_transparent_r1: assert (held_addr == addr_i)
        else $error("held address does not follow input while strobe high");
    if (inhibit_i)
      p_inhibit_quiet_r5: assert (act == '0)
        else $error("active line present during inhibit");
    if (primed && !inhibit_i) begin
      p_single_line_r3: assert ($countones(act) == 1)
        else $error("not exactly one active line");
      p_line_matches_r3: assert (act[held_addr] == 1'b1)
        else $error("active line does not match held address");
    end
  end
endmodule

bind latched_line_decoder lld_checker #(.ADDR_W(ADDR_W), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
  .strobe_i  (strobe_i),
  .inhibit_i (inhibit_i),
  .addr_i    (addr_i),
  .held_addr (held_addr),
  .sel_o     (sel_o)
);

// File: tb/tb_latched_line_decoder.sv
module tb_latched_line_decoder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        strobe = 1'b0;
  logic        inhibit = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [15:0] sel_hi, sel_lo;

  int checks = 0;
  int fails  = 0;
  logic [3:0] model_held = 4'd0;

  latched_line_decoder dut (
    .strobe_i(strobe), .inhibit_i(inhibit), .addr_i(addr), .sel_o(sel_hi));

  latched_line_decoder #(.ACTIVE_LOW(1'b1)) dut_n (
    .strobe_i(strobe), .inhibit_i(inhibit), .addr_i(addr), .sel_o(sel_lo));

  // Expected bus built by shifting, independent of the design structure.
  function automatic logic [15:0] expect_bus(input logic [3:0] a, input logic inh,
                                             input logic low);
    logic [15:0] v;
    v = inh ? 16'h0000 : (16'h0001 << a);
    return low ? ~v : v;
  endfunction

  task automatic check(input string req);
    logic [15:0] eh, el;
    eh = expect_bus(model_held, inhibit, 1'b0);
    el = expect_bus(model_held, inhibit, 1'b1);
    checks++;
    if (sel_hi !== eh) begin
      fails++;
      $display("FAIL %s high build: got %h expected %h", req, sel_hi, eh);
    end
    checks++;
    if (sel_lo !== el) begin
      fails++;
      $display("FAIL %s low build: got %h expected %h", req, sel_lo, el);
    end
    checks++;
    if (sel_lo !== ~sel_hi) begin
      fails++;
      $display("FAIL R7 complement: got %h expected %h", sel_lo, ~sel_hi);
    end
  endtask

  // Strobe first, then data; the model follows the same order.
  task automatic apply(input logic s, input logic inh, input logic [3:0] a, input string req);
    @(negedge clk);
    strobe = s;
    if (s) model_held = addr;
    #1;
    addr = a;
    inhibit = inh;
    if (s) model_held = a;
    @(posedge clk);
    #1;
    check(req);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // Prime the holding stage, then take the reset-state view (address 0).
    apply(1'b1, 1'b0, 4'd0, "R3 initial");
    // R8: default build is active-high, so S0 is bit 0 high.
    checks++;
    if (sel_hi !== 16'h0001) begin
      fails++;
      $display("FAIL R8 default polarity: got %h expected %h", sel_hi, 16'h0001);
    end
    // R1/R3: sweep all addresses transparently.
    for (int i = 0; i < 16; i++) apply(1'b1, 1'b0, 4'(i), "R1 sweep");
    // R4: bit weights.
    apply(1'b1, 1'b0, 4'b0001, "R4 A only");
    checks++;
    if (sel_hi !== 16'h0002) begin
      fails++;
      $display("FAIL R4 weight A: got %h expected %h", sel_hi, 16'h0002);
    end
    apply(1'b1, 1'b0, 4'b1000, "R4 D only");
    checks++;
    if (sel_hi !== 16'h0100) begin
      fails++;
      $display("FAIL R4 weight D: got %h expected %h", sel_hi, 16'h0100);
    end
    // R2: hold address 5 across a strobe fall while inputs move.
    apply(1'b1, 1'b0, 4'd5, "R1 load");
    apply(1'b0, 1'b0, 4'd5, "R2 fall");
    for (int i = 0; i < 6; i++) apply(1'b0, 1'b0, 4'(i * 3 + 1), "R2 hold");
    checks++;
    if (sel_hi !== 16'h0020) begin
      fails++;
      $display("FAIL R2 held value: got %h expected %h", sel_hi, 16'h0020);
    end
    // R5: inhibit with several addresses.
    for (int i = 0; i < 4; i++) apply(1'b0, 1'b1, 4'(i * 5), "R5 inhibit");
    // R6: load address 12 during inhibit, then release.
    apply(1'b1, 1'b1, 4'd12, "R6 load under inhibit");
    apply(1'b0, 1'b1, 4'd12, "R6 fall under inhibit");
    apply(1'b0, 1'b0, 4'd3, "R6 release");
    checks++;
    if (sel_hi !== 16'h1000) begin
      fails++;
      $display("FAIL R6 after release: got %h expected %h", sel_hi, 16'h1000);
    end
    // Random mix.
    for (int i = 0; i < 400; i++) begin
      logic s, inh;
      s   = ($urandom % 3) == 0;
      inh = ($urandom % 4) == 0;
      apply(s, inh, 4'($urandom), "R3 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule